// File: doc/BRIEF.md
# Cascadable Cache Tag Store with Comparator

This block is the tag memory of a synchronous, direct-mapped cache. Each line entry holds a tag together with three status bits: valid, dirty and write-through. An access presents a line index and an incoming tag. The block reads the stored tag and status at that index and reports whether the line hits. A hit means the tags are equal and the line is valid. The same access can also store a new tag, new status, or both, under two independent write enables.

Two chip selects of opposite polarity let two copies share one set of output wires. Tie one low-order address bit to the active-low select of one copy and to the active-high select of the other. Then exactly one copy answers, and the pair has twice the depth. Every output comes with its own enable, which stands in for a tri-state driver.

A synchronous reset does not clear the tag array. It clears the status array by sweeping one entry per clock, so every line ends up invalid. A busy flag covers the whole sweep. Power-down keeps the contents and silences the match and status outputs.

Top module: `cache_tag_store`

## Requirements
- R1: The block is selected only when `cs_n` is 0 and `cs` is 1. An access sampled while deselected writes nothing, and all three output enables are 0 after that edge.
- R2: Inputs are sampled on the rising edge, and the outputs present the result after that same edge. A read returns the array contents from before that edge's write. A read of the same index one cycle later returns the newly written tag and status.
- R3: `match` is 1 only when the block was active at the sampling edge, the stored tag equals `tag_in`, and the stored valid bit is 1. The status field is `st_in`/`st_out`, with bit 2 = valid, bit 1 = dirty and bit 0 = write-through.
- R4: `tag_we` writes only the tag array and `st_we` writes only the status array.
- R5: `tag_out_en` follows `tag_oe` and `st_out_en` follows `st_oe`, each sampled with an active access. `match_en` is 1 for every active access. Any output whose enable is 0 reads as 0.
- R6: While `rst` is 1, `busy` is 1. After `rst` falls, `busy` stays 1 for exactly 2**IDX_W further edges. When it falls, every valid bit is 0 and every stored tag is unchanged.
- R7: While `busy` is 1, accesses are ignored: nothing is written and all output enables are 0.
- R8: While `pwr_dn` is 1, accesses are ignored. `match` and `st_out_en` are 0 after the edge, and the array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, starts the status sweep |
| pwr_dn | input | 1 | Power-down: blocks accesses, keeps contents |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| idx | input | IDX_W | Line index |
| tag_in | input | TAG_W | Incoming tag for compare or write |
| st_in | input | 3 | Status to write {valid, dirty, write-through} |
| tag_we | input | 1 | Tag write enable |
| st_we | input | 1 | Status write enable |
| tag_oe | input | 1 | Tag output enable |
| st_oe | input | 1 | Status output enable |
| tag_out | output | TAG_W | Stored tag read |
| tag_out_en | output | 1 | Drive enable for tag_out |
| st_out | output | 3 | Stored status read |
| st_out_en | output | 1 | Drive enable for st_out |
| match | output | 1 | Hit flag |
| match_en | output | 1 | Drive enable for match |
| busy | output | 1 | Status sweep in progress |

## Verification
The hardest case to reach from the ports is an access that lands during the reset sweep. The access targets an entry the sweep has already cleared, so any write that slipped through would survive. The stimulus holds a status write with valid=1 to index 0 over the last cycles of the sweep. It then reads index 0 and expects an invalid line. A line that was valid with a known tag is also read after the sweep, which shows that the tag survived while the valid bit did not. Constrained random traffic then mixes both select polarities, power-down, and hits against a bench model of both arrays.

// File: rtl/tagram_pkg.sv
package tagram_pkg;
   localparam int ST_W = 3;

   typedef struct packed {
      logic valid;
      logic dirty;
      logic wthru;
   } line_st_t;

   function automatic line_st_t st_clear();
      line_st_t s;
      s = '{valid: 1'b0, dirty: 1'b0, wthru: 1'b0};
      return s;
   endfunction
endpackage

// File: rtl/tag_array.sv
module tag_array #(
   parameter int IDX_W = 8,
   parameter int TAG_W = 12
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag
);
   localparam int DEPTH = 1 << IDX_W;

   logic [TAG_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wr_idx] <= wr_tag;
   end

   assign rd_tag = mem[rd_idx];
endmodule

// File: rtl/status_array.sv
module status_array
   import tagram_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [IDX_W-1:0] wr_idx,
   input  line_st_t         wr_st,
   input  logic [IDX_W-1:0] rd_idx,
   output line_st_t         rd_st,
   output logic             busy
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

   line_st_t         mem [DEPTH];
   logic [IDX_W-1:0] sweep_ptr;
   logic             sweep_on;

   always_ff @(posedge clk) begin
      if (rst) begin
         sweep_ptr <= '0;
         sweep_on  <= 1'b1;
      end else if (sweep_on) begin
         sweep_ptr <= sweep_ptr + 1'b1;
         if (sweep_ptr == LAST) sweep_on <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         mem[0] <= st_clear();
      else if (sweep_on)
         mem[sweep_ptr] <= st_clear();
      else if (we)
         mem[wr_idx] <= wr_st;
   end

   assign rd_st = mem[rd_idx];
   assign busy  = sweep_on;
endmodule

// File: rtl/tag_cmp.sv
module tag_cmp #(
   parameter int TAG_W     = 12,
   parameter bit REQ_VALID = 1'b1
) (
   input  logic [TAG_W-1:0] stored,
   input  logic [TAG_W-1:0] probe,
   input  logic             valid,
   output logic             hit
);
   logic [TAG_W-1:0] bit_eq;
   logic             all_eq;

   for (genvar b = 0; b < TAG_W; b++) begin : g_bit
      assign bit_eq[b] = ~(stored[b] ^ probe[b]);
   end

   assign all_eq = &bit_eq;

   if (REQ_VALID) begin : g_gate
      assign hit = all_eq & valid;
   end else begin : g_nogate
      logic unused_valid;
      assign unused_valid = valid;
      assign hit = all_eq;
   end
endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store
   import tagram_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int TAG_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pwr_dn,
   input  logic             cs_n,
   input  logic             cs,
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] tag_in,
   input  logic [2:0]       st_in,
   input  logic             tag_we,
   input  logic             st_we,
   input  logic             tag_oe,
   input  logic             st_oe,
   output logic [TAG_W-1:0] tag_out,
   output logic             tag_out_en,
   output logic [2:0]       st_out,
   output logic             st_out_en,
   output logic             match,
   output logic             match_en,
   output logic             busy
);
   if (IDX_W < 1 || IDX_W > 20) begin : g_bad_idx
      $error("cache_tag_store: IDX_W out of range");
   end
   if (TAG_W < 1 || TAG_W > 64) begin : g_bad_tag
      $error("cache_tag_store: TAG_W out of range");
   end
   if (ST_W != 3) begin : g_bad_st
      $error("cache_tag_store: status width must be 3");
   end

   logic             selected;
   logic             access;
   logic             sweep_busy;
   logic [TAG_W-1:0] arr_tag;
   line_st_t         arr_st;
   line_st_t         wr_st;

   logic             q_act;
   logic             q_toe;
   logic             q_soe;
   logic [TAG_W-1:0] q_tag;
   line_st_t         q_st;
   logic [TAG_W-1:0] q_probe;
   logic             hit;

   assign selected = ~cs_n & cs;
   assign access   = selected & ~sweep_busy & ~pwr_dn & ~rst;
   assign wr_st    = line_st_t'(st_in);

   tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk    (clk),
      .we     (access & tag_we),
      .wr_idx (idx),
      .wr_tag (tag_in),
      .rd_idx (idx),
      .rd_tag (arr_tag)
   );

   status_array #(.IDX_W(IDX_W)) u_stat (
      .clk    (clk),
      .rst    (rst),
      .we     (access & st_we),
      .wr_idx (idx),
      .wr_st  (wr_st),
      .rd_idx (idx),
      .rd_st  (arr_st),
      .busy   (sweep_busy)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         q_act <= 1'b0;
         q_toe <= 1'b0;
         q_soe <= 1'b0;
      end else begin
         q_act <= access;
         q_toe <= access & tag_oe;
         q_soe <= access & st_oe;
      end
   end

   always_ff @(posedge clk) begin
      if (access) begin
         q_tag   <= arr_tag;
         q_st    <= arr_st;
         q_probe <= tag_in;
      end
   end

   tag_cmp #(.TAG_W(TAG_W), .REQ_VALID(1'b1)) u_cmp (
      .stored (q_tag),
      .probe  (q_probe),
      .valid  (q_st.valid),
      .hit    (hit)
   );

   assign tag_out_en = q_toe;
   assign st_out_en  = q_soe;
   assign match_en   = q_act;
   assign match      = q_act & hit;
   assign tag_out    = q_toe ? q_tag : '0;
   assign st_out     = q_soe ? 3'(q_st) : 3'b000;
   assign busy       = sweep_busy;
endmodule

// File: rtl/cache_tag_store_chk.sv
module cache_tag_store_chk (
   input logic clk,
   input logic rst,
   input logic pwr_dn,
   input logic cs_n,
   input logic cs,
   input logic tag_oe,
   input logic st_oe,
   input logic tag_out_en,
   input logic st_out_en,
   input logic match,
   input logic match_en,
   input logic busy
);
   assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      !(!cs_n && cs) |=> (!tag_out_en && !st_out_en && !match_en));

   assert_match_enabled_R3: assert property (@(posedge clk) disable iff (rst)
      match |-> match_en);

   assert_tag_oe_R5: assert property (@(posedge clk) disable iff (rst)
      !tag_oe |=> !tag_out_en);

   assert_st_oe_R5: assert property (@(posedge clk) disable iff (rst)
      !st_oe |=> !st_out_en);

   assert_busy_on_release_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> busy);

   assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (rst)
      busy |=> !match_en);

   assert_pwrdn_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      pwr_dn |=> (!match && !st_out_en));
endmodule

bind cache_tag_store cache_tag_store_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .pwr_dn     (pwr_dn),
   .cs_n       (cs_n),
   .cs         (cs),
   .tag_oe     (tag_oe),
   .st_oe      (st_oe),
   .tag_out_en (tag_out_en),
   .st_out_en  (st_out_en),
   .match      (match),
   .match_en   (match_en),
   .busy       (busy)
);

// File: tb/sim_cache_tag_store.sv
`timescale 1ns/1ps
module sim_cache_tag_store;
   localparam int IDX_W = 8;
   localparam int TAG_W = 12;
   localparam int DEPTH = 1 << IDX_W;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             pwr_dn = 1'b0;
   logic             cs_n = 1'b1;
   logic             cs = 1'b0;
   logic [IDX_W-1:0] idx = '0;
   logic [TAG_W-1:0] tag_in = '0;
   logic [2:0]       st_in = '0;
   logic             tag_we = 1'b0;
   logic             st_we = 1'b0;
   logic             tag_oe = 1'b0;
   logic             st_oe = 1'b0;
   logic [TAG_W-1:0] tag_out;
   logic             tag_out_en;
   logic [2:0]       st_out;
   logic             st_out_en;
   logic             match;
   logic             match_en;
   logic             busy;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [TAG_W-1:0] ref_tag [DEPTH];
   logic [2:0]       ref_st  [DEPTH];

   always #2 clk = ~clk;

   cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u0 (
      .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .cs_n(cs_n), .cs(cs),
      .idx(idx), .tag_in(tag_in), .st_in(st_in), .tag_we(tag_we),
      .st_we(st_we), .tag_oe(tag_oe), .st_oe(st_oe), .tag_out(tag_out),
      .tag_out_en(tag_out_en), .st_out(st_out), .st_out_en(st_out_en),
      .match(match), .match_en(match_en), .busy(busy)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_in(input bit sn, input bit sp, input bit pd,
                         input int ix, input logic [TAG_W-1:0] tg,
                         input logic [2:0] st, input bit twe, input bit swe,
                         input bit toe, input bit soe);
      cs_n = sn; cs = sp; pwr_dn = pd; idx = IDX_W'(ix); tag_in = tg;
      st_in = st; tag_we = twe; st_we = swe; tag_oe = toe; st_oe = soe;
   endtask

   // one access; expected outputs come from the model before this edge's write
   task automatic tick(input string req);
      logic act;
      logic [TAG_W-1:0] et;
      logic [2:0] es;
      logic hit;
      act = !cs_n && cs && !pwr_dn && !rst;
      et  = ref_tag[idx];
      es  = ref_st[idx];
      hit = act && (et == tag_in) && es[2];
      if (act && tag_we) ref_tag[idx] = tag_in;
      if (act && st_we)  ref_st[idx]  = st_in;
      @(posedge clk); #1;
      check(req, "tag_out_en", 32'(tag_out_en), 32'(act && tag_oe));
      check(req, "st_out_en",  32'(st_out_en),  32'(act && st_oe));
      check(req, "match_en",   32'(match_en),   32'(act));
      check(req, "match",      32'(match),      32'(hit));
      check(req, "tag_out",    32'(tag_out),    (act && tag_oe) ? 32'(et) : 32'd0);
      check(req, "st_out",     32'(st_out),     (act && st_oe) ? 32'(es) : 32'd0);
      check(req, "busy",       32'(busy),       32'd0);
   endtask

   // reset with an access held over the tail of the sweep (R6, R7)
   task automatic do_reset();
      int n;
      rst = 1'b1;
      set_in(1'b0, 1'b1, 1'b0, 0, '0, 3'b100, 1'b0, 1'b1, 1'b1, 1'b1);
      repeat (3) begin
         @(posedge clk); #1;
         check("R6", "busy during reset", 32'(busy), 32'd1);
         check("R7", "match_en during reset", 32'(match_en), 32'd0);
      end
      rst = 1'b0;
      n = 0;
      while (busy && n < DEPTH + 10) begin
         @(posedge clk); #1;
         n++;
         if (busy) check("R7", "match_en while busy", 32'(match_en), 32'd0);
      end
      check("R6", "sweep length", 32'(n), 32'(DEPTH));
      set_in(1'b1, 1'b0, 1'b0, 0, '0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < DEPTH; i++) ref_st[i] = 3'b000;
   endtask

   initial begin
      logic [TAG_W-1:0] t5;
      void'($urandom(32'h1234_5eed));
      do_reset();

      // fill every tag, status untouched (R4)
      for (int i = 0; i < DEPTH; i++) begin
         set_in(1'b0, 1'b1, 1'b0, i, TAG_W'($urandom), 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
         tick("R4");
      end
      t5 = ref_tag[5];
      // equal tag but invalid line: no hit (R3); status still cleared (R4)
      set_in(1'b0, 1'b1, 1'b0, 5, t5, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1);
      tick("R3");
      // status-only write, then read back the hit (R2, R4)
      set_in(1'b0, 1'b1, 1'b0, 5, ~t5, 3'b110, 1'b0, 1'b1, 1'b1, 1'b1);
      tick("R4");
      set_in(1'b0, 1'b1, 1'b0, 5, t5, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1);
      tick("R2");
      set_in(1'b0, 1'b1, 1'b0, 5, t5 ^ 12'h001, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1);
      tick("R3");
      // deselected writes, both polarities (R1)
      set_in(1'b1, 1'b1, 1'b0, 5, ~t5, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1);
      tick("R1");
      set_in(1'b0, 1'b0, 1'b0, 5, ~t5, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1);
      tick("R1");
      set_in(1'b0, 1'b1, 1'b0, 5, t5, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1);
      tick("R1");
      check("R1", "hit kept after deselected write", 32'(match), 32'd1);
      // power-down write ignored, contents kept (R8)
      set_in(1'b0, 1'b1, 1'b1, 5, ~t5, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1);
      tick("R8");
      set_in(1'b0, 1'b1, 1'b0, 5, t5, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1);
      tick("R8");
      check("R8", "hit kept after power-down", 32'(match), 32'd1);
      // output enables independent (R5)
      set_in(1'b0, 1'b1, 1'b0, 5, t5, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);
      tick("R5");
      set_in(1'b0, 1'b1, 1'b0, 5, t5, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0);
      tick("R5");

      // reset: tags kept, valid bits cleared, write during sweep dropped (R6, R7)
      do_reset();
      set_in(1'b0, 1'b1, 1'b0, 5, t5, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1);
      tick("R6");
      check("R6", "tag kept over reset", 32'(tag_out), 32'(t5));
      set_in(1'b0, 1'b1, 1'b0, 0, ref_tag[0], 3'b000, 1'b0, 1'b0, 1'b1, 1'b1);
      tick("R7");
      check("R7", "valid after write during sweep", 32'(st_out[2]), 32'd0);

      // constrained random traffic (R1..R5, R8)
      for (int k = 0; k < 4000; k++) begin
         int ix;
         bit sel;
         logic [TAG_W-1:0] tg;
         ix  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, DEPTH - 1))
                                           : int'($urandom_range(0, 7));
         tg  = ($urandom_range(0, 1) == 0) ? ref_tag[ix] : TAG_W'($urandom);
         sel = ($urandom_range(0, 99) < 85);
         if (sel)
            set_in(1'b0, 1'b1, ($urandom_range(0, 19) == 0), ix, tg,
                   3'($urandom), ($urandom_range(0, 9) < 2), ($urandom_range(0, 9) < 3),
                   ($urandom_range(0, 9) < 8), ($urandom_range(0, 9) < 8));
         else
            set_in($urandom_range(0, 1) == 1, 1'b0, 1'b0, ix, tg, 3'($urandom),
                   1'b1, 1'b1, 1'b1, 1'b1);
         tick(sel ? "R2" : "R1");
      end

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule